// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit commits a trap in a hart once an exception or interrupt has already been picked. It receives the cause number, a flag that marks the trap as an interrupt, the faulting address, the PC of the trapping instruction, the current privilege level, the two delegation masks, the status word and the two trap-vector registers. One clock edge after a trap is presented, it returns everything the privileged state needs for the commit. That is the target privilege, the updated status word, the cause, exception-PC and trap-value register writes, and the PC of the handler.

The target level is supervisor only when the hart runs at user or supervisor level and the selected delegation mask has the bit for the cause set. Every other trap goes to machine level. An environment call is reported on the single user-call cause and is renamed to the caller's own level before delegation is decided. A vector register whose mode field selects vectored entry moves interrupts to a per-cause slot. Exceptions always enter at the base.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted and until the first trap, commitValid is 0 and every result output is zero.
- R2: Results appear on the clock edge after a cycle with trapValid high and are then held. commitValid is high for exactly that one cycle per trap.
- R3: Privilege is encoded user=0, supervisor=1, machine=3. The trap targets supervisor (newPriv=1, trapToSuper=1) when curPriv is 0 or 1 and bit <cause> of intDeleg (interrupts) or of excDeleg (exceptions) is 1. Otherwise it targets machine (newPriv=3, trapToSuper=0).
- R4: A cause number of XLEN or above is never delegated, whatever the delegation masks hold.
- R5: On supervisor entry, status bit 5 takes old bit 1, bit 8 takes curPriv bit 0, bit 1 is cleared, and all other bits are kept.
- R6: On machine entry, status bit 7 takes old bit 3, bits 12:11 take curPriv, bit 3 is cleared, and all other bits are kept.
- R7: causeOut holds the final cause number zero-extended, with bit XLEN-1 set for interrupts and clear for exceptions.
- R8: epcOut equals trapPc for both targets.
- R9: tvalOut equals trapAddr for exceptions with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15, and is zero for every other exception and for all interrupts.
- R10: An exception with cause 8 becomes cause 8 from user level, 9 from supervisor level and 11 from machine level. Delegation, causeOut and tvalOut then use the converted number.
- R11: The handler PC is the target's vector register with bits 1:0 cleared when that register's bits 1:0 are 0, 2 or 3, and also for every exception.
- R12: When the target's vector register has bits 1:0 equal to 1 and the trap is an interrupt, the handler PC is the cleared base plus four times the cause.
- R13: Supervisor entry takes its vector from sVecReg and machine entry takes it from mVecReg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | A selected trap is presented this cycle |
| trapAsync | input | 1 | 1 = interrupt, 0 = exception |
| trapCause | input | CAUSE_W | Cause number before environment-call renaming |
| trapAddr | input | XLEN | Faulting address for address-bearing exceptions |
| trapPc | input | XLEN | PC of the trapping instruction |
| curPriv | input | 2 | Current privilege level |
| excDeleg | input | XLEN | Exception delegation mask |
| intDeleg | input | XLEN | Interrupt delegation mask |
| statusIn | input | XLEN | Current status word |
| sVecReg | input | XLEN | Supervisor trap-vector register (base and mode) |
| mVecReg | input | XLEN | Machine trap-vector register (base and mode) |
| commitValid | output | 1 | Results below belong to the trap of the previous cycle |
| newPriv | output | 2 | Privilege level after the trap |
| trapToSuper | output | 1 | 1 = supervisor register set is written, 0 = machine set |
| statusOut | output | XLEN | Updated status word |
| causeOut | output | XLEN | Value for the target's cause register |
| epcOut | output | XLEN | Value for the target's exception-PC register |
| tvalOut | output | XLEN | Value for the target's trap-value register |
| nextPc | output | XLEN | Handler entry PC |

## Verification
The hardest cases to reach are the ones where two rules interact. One is a cause number at or above the register width while every delegation bit is set. Another is an environment call whose renamed cause hits a different delegation bit than the raw one. A third is a vectored register paired with an exception, which must not be offset. The stimulus drives the full cause range of the input port under all-ones, all-zeros and alternating delegation masks, from each legal privilege level. It covers all four vector mode values, and directed scenarios set only the renamed bit for environment calls.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    PRIV_USER    = 2'd0,
    PRIV_SUPER   = 2'd1,
    PRIV_RSVD    = 2'd2,
    PRIV_MACHINE = 2'd3
  } priv_e;

  // Status word bit positions decoded by the rest of the hart
  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;

  // Raw environment-call cause; renamed to base + privilege
  localparam int ECALL_BASE = 8;

  // Causes that carry a faulting address (bit n set = cause n)
  localparam logic [15:0] ADDR_CAUSE_MASK = 16'b1011_0000_1111_0011;

  // Vector mode field value that selects per-cause interrupt slots
  localparam logic [1:0] VEC_MODE_SLOTS = 2'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic commit;
    logic toSuper;
    logic useAddr;
    logic vecAdd;
    logic isAsync;
  } trap_strobe_t;

endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               trapValid,
  input  logic               trapAsync,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [XLEN-1:0]    intDeleg,
  input  logic [1:0]         sVecMode,
  input  logic [1:0]         mVecMode,
  output trap_strobe_t       strobe,
  output logic [CAUSE_W-1:0] finalCause
);

  localparam int IDX_W = $clog2(XLEN);

  logic              isEcall;
  logic [XLEN-1:0]   delegSel;
  logic              causeInRange;
  logic [IDX_W-1:0]  causeIdx;
  logic              delegBit;
  logic              lowPriv;
  logic              toSuper;
  logic              smallCause;
  logic [1:0]        targetMode;

  // Environment-call renaming to the caller's own level
  always_comb begin
    isEcall    = !trapAsync && (trapCause == CAUSE_W'(ECALL_BASE));
    finalCause = isEcall ? (CAUSE_W'(ECALL_BASE) + CAUSE_W'(curPriv)) : trapCause;
  end

  // Range check of the cause against the mask width
  generate
    if (CAUSE_W > IDX_W) begin : g_wideCause
      assign causeInRange = (finalCause[CAUSE_W-1:IDX_W] == '0);
      assign causeIdx     = finalCause[IDX_W-1:0];
    end else begin : g_narrowCause
      assign causeInRange = 1'b1;
      assign causeIdx     = IDX_W'(finalCause);
    end
  endgenerate

  always_comb begin
    delegSel   = trapAsync ? intDeleg : excDeleg;
    delegBit   = causeInRange && delegSel[causeIdx];
    lowPriv    = (curPriv == PRIV_USER) || (curPriv == PRIV_SUPER);
    toSuper    = lowPriv && delegBit;
    smallCause = (finalCause >> 4) == '0;
    targetMode = toSuper ? sVecMode : mVecMode;
  end

  always_comb begin
    strobe.commit  = trapValid;
    strobe.toSuper = toSuper;
    strobe.isAsync = trapAsync;
    strobe.useAddr = !trapAsync && smallCause && ADDR_CAUSE_MASK[finalCause[3:0]];
    strobe.vecAdd  = trapAsync && (targetMode == VEC_MODE_SLOTS);
  end

endmodule

// File: rtl/trap_entry_dpath.sv
module trap_entry_dpath
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  trap_strobe_t       strobe,
  input  logic [CAUSE_W-1:0] finalCause,
  input  logic [XLEN-1:0]    trapAddr,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    statusIn,
  input  logic [XLEN-1:0]    sVecReg,
  input  logic [XLEN-1:0]    mVecReg,
  output logic               commitValid,
  output logic [1:0]         newPriv,
  output logic               trapToSuper,
  output logic [XLEN-1:0]    statusOut,
  output logic [XLEN-1:0]    causeOut,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    tvalOut,
  output logic [XLEN-1:0]    nextPc
);

  localparam logic [XLEN-1:0] BASE_MASK = ~XLEN'(3);

  logic [XLEN-1:0] statusNext;
  logic [XLEN-1:0] causeNext;
  logic [XLEN-1:0] tvalNext;
  logic [XLEN-1:0] vecBase;
  logic [XLEN-1:0] vecOffset;
  logic [XLEN-1:0] pcNext;
  logic [1:0]      privNext;

  always_comb begin
    statusNext = statusIn;
    if (strobe.toSuper) begin
      statusNext[ST_SPIE] = statusIn[ST_SIE];
      statusNext[ST_SPP]  = curPriv[0];
      statusNext[ST_SIE]  = 1'b0;
    end else begin
      statusNext[ST_MPIE]        = statusIn[ST_MIE];
      statusNext[ST_MPP_LO +: 2] = curPriv;
      statusNext[ST_MIE]         = 1'b0;
    end
  end

  always_comb begin
    causeNext         = XLEN'(finalCause);
    causeNext[XLEN-1] = strobe.isAsync;
    tvalNext          = strobe.useAddr ? trapAddr : '0;
    privNext          = strobe.toSuper ? PRIV_SUPER : PRIV_MACHINE;
  end

  always_comb begin
    vecBase   = (strobe.toSuper ? sVecReg : mVecReg) & BASE_MASK;
    vecOffset = strobe.vecAdd ? (XLEN'(finalCause) << 2) : '0;
    pcNext    = vecBase + vecOffset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitValid <= 1'b0;
      newPriv     <= '0;
      trapToSuper <= 1'b0;
      statusOut   <= '0;
      causeOut    <= '0;
      epcOut      <= '0;
      tvalOut     <= '0;
      nextPc      <= '0;
    end else begin
      commitValid <= strobe.commit;
      if (strobe.commit) begin
        newPriv     <= privNext;
        trapToSuper <= strobe.toSuper;
        statusOut   <= statusNext;
        causeOut    <= causeNext;
        epcOut      <= trapPc;
        tvalOut     <= tvalNext;
        nextPc      <= pcNext;
      end
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic               trapAsync,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapAddr,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [XLEN-1:0]    intDeleg,
  input  logic [XLEN-1:0]    statusIn,
  input  logic [XLEN-1:0]    sVecReg,
  input  logic [XLEN-1:0]    mVecReg,
  output logic               commitValid,
  output logic [1:0]         newPriv,
  output logic               trapToSuper,
  output logic [XLEN-1:0]    statusOut,
  output logic [XLEN-1:0]    causeOut,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    tvalOut,
  output logic [XLEN-1:0]    nextPc
);

  trap_strobe_t       strobe;
  logic [CAUSE_W-1:0] finalCause;

  trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) ctrl_i (
    .trapValid (trapValid),
    .trapAsync (trapAsync),
    .trapCause (trapCause),
    .curPriv   (curPriv),
    .excDeleg  (excDeleg),
    .intDeleg  (intDeleg),
    .sVecMode  (sVecReg[1:0]),
    .mVecMode  (mVecReg[1:0]),
    .strobe    (strobe),
    .finalCause(finalCause)
  );

  trap_entry_dpath #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .finalCause (finalCause),
    .trapAddr   (trapAddr),
    .trapPc     (trapPc),
    .curPriv    (curPriv),
    .statusIn   (statusIn),
    .sVecReg    (sVecReg),
    .mVecReg    (mVecReg),
    .commitValid(commitValid),
    .newPriv    (newPriv),
    .trapToSuper(trapToSuper),
    .statusOut  (statusOut),
    .causeOut   (causeOut),
    .epcOut     (epcOut),
    .tvalOut    (tvalOut),
    .nextPc     (nextPc)
  );

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               trapValid,
  input logic               trapAsync,
  input logic [CAUSE_W-1:0] trapCause,
  input logic [XLEN-1:0]    trapPc,
  input logic [1:0]         curPriv,
  input logic               commitValid,
  input logic [1:0]         newPriv,
  input logic               trapToSuper,
  input logic [XLEN-1:0]    statusOut,
  input logic [XLEN-1:0]    causeOut,
  input logic [XLEN-1:0]    epcOut,
  input logic [XLEN-1:0]    tvalOut,
  input logic [XLEN-1:0]    nextPc
);

  assert_commit_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> commitValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !commitValid);

  assert_machine_stays_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == 2'd3) |=> (newPriv == 2'd3 && !trapToSuper));

  assert_wide_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && int'(trapCause) >= XLEN) |=> (newPriv == 2'd3));

  assert_super_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && trapToSuper) |-> (!statusOut[1] && newPriv == 2'd1));

  assert_machine_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !trapToSuper) |-> (!statusOut[3] && newPriv == 2'd3));

  assert_cause_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (causeOut[XLEN-1] == $past(trapAsync)));

  assert_epc_copy_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (epcOut == $past(trapPc)));

  assert_irq_tval_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && trapAsync) |=> (tvalOut == '0));

  assert_pc_aligned_R11: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (nextPc[1:0] == 2'b00));

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .trapValid  (trapValid),
  .trapAsync  (trapAsync),
  .trapCause  (trapCause),
  .trapPc     (trapPc),
  .curPriv    (curPriv),
  .commitValid(commitValid),
  .newPriv    (newPriv),
  .trapToSuper(trapToSuper),
  .statusOut  (statusOut),
  .causeOut   (causeOut),
  .epcOut     (epcOut),
  .tvalOut    (tvalOut),
  .nextPc     (nextPc)
);

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;

  localparam int XLEN    = 32;
  localparam int CAUSE_W = 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               trapValid = 1'b0;
  logic               trapAsync = 1'b0;
  logic [CAUSE_W-1:0] trapCause = '0;
  logic [XLEN-1:0]    trapAddr = '0;
  logic [XLEN-1:0]    trapPc = '0;
  logic [1:0]         curPriv = '0;
  logic [XLEN-1:0]    excDeleg = '0;
  logic [XLEN-1:0]    intDeleg = '0;
  logic [XLEN-1:0]    statusIn = '0;
  logic [XLEN-1:0]    sVecReg = '0;
  logic [XLEN-1:0]    mVecReg = '0;
  logic               commitValid;
  logic [1:0]         newPriv;
  logic               trapToSuper;
  logic [XLEN-1:0]    statusOut;
  logic [XLEN-1:0]    causeOut;
  logic [XLEN-1:0]    epcOut;
  logic [XLEN-1:0]    tvalOut;
  logic [XLEN-1:0]    nextPc;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut_i (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapAsync(trapAsync),
    .trapCause(trapCause), .trapAddr(trapAddr), .trapPc(trapPc),
    .curPriv(curPriv), .excDeleg(excDeleg), .intDeleg(intDeleg),
    .statusIn(statusIn), .sVecReg(sVecReg), .mVecReg(mVecReg),
    .commitValid(commitValid), .newPriv(newPriv), .trapToSuper(trapToSuper),
    .statusOut(statusOut), .causeOut(causeOut), .epcOut(epcOut),
    .tvalOut(tvalOut), .nextPc(nextPc)
  );

  task automatic check(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive a trap at a falling edge, sample one full cycle later, compare
  // against a model derived from the requirements.
  task automatic runTrap(input logic a, input int c, input logic [1:0] p,
                         input logic [XLEN-1:0] eD, input logic [XLEN-1:0] iD,
                         input logic [XLEN-1:0] st, input logic [XLEN-1:0] sV,
                         input logic [XLEN-1:0] mV, input logic [XLEN-1:0] addr,
                         input logic [XLEN-1:0] pc, input string tag);
    int fc;
    logic dbit, toS;
    logic [XLEN-1:0] expSt, expCause, expTval, expPc, vec;
    trapAsync = a; trapCause = CAUSE_W'(c); curPriv = p;
    excDeleg = eD; intDeleg = iD; statusIn = st; sVecReg = sV; mVecReg = mV;
    trapAddr = addr; trapPc = pc; trapValid = 1'b1;
    @(negedge clk);
    trapValid = 1'b0;
    // R10 renaming
    fc = (!a && c == 8) ? 8 + int'(p) : c;
    // R3 / R4 delegation
    dbit = (fc < XLEN) ? (a ? iD[fc] : eD[fc]) : 1'b0;
    toS  = (p == 2'd0 || p == 2'd1) && dbit;
    expSt = st;
    if (toS) begin
      expSt[5] = st[1]; expSt[8] = p[0]; expSt[1] = 1'b0;
    end else begin
      expSt[7] = st[3]; expSt[12:11] = p; expSt[3] = 1'b0;
    end
    expCause = XLEN'(fc); expCause[XLEN-1] = a;
    expTval = (!a && (fc == 0 || fc == 1 || (fc >= 4 && fc <= 7) ||
               fc == 12 || fc == 13 || fc == 15)) ? addr : '0;
    vec = toS ? sV : mV;
    expPc = {vec[XLEN-1:2], 2'b00};
    if (a && vec[1:0] == 2'd1) expPc = expPc + XLEN'(4 * fc);
    check({tag, " R2"}, "commitValid", XLEN'(commitValid), XLEN'(1));
    check({tag, " R3"}, "newPriv", XLEN'(newPriv), toS ? XLEN'(1) : XLEN'(3));
    check({tag, " R3"}, "trapToSuper", XLEN'(trapToSuper), XLEN'(toS));
    check({tag, toS ? " R5" : " R6"}, "statusOut", statusOut, expSt);
    check({tag, " R7"}, "causeOut", causeOut, expCause);
    check({tag, " R8"}, "epcOut", epcOut, pc);
    check({tag, " R9"}, "tvalOut", tvalOut, expTval);
    check({tag, (a && vec[1:0] == 2'd1) ? " R12" : " R11"}, "nextPc", nextPc, expPc);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    trapValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "commitValid", XLEN'(commitValid), '0);
    check("R1", "statusOut", statusOut, '0);
    check("R1", "nextPc", nextPc, '0);
    trapValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "commitValid idle", XLEN'(commitValid), '0);
    check("R1", "causeOut idle", causeOut, '0);
  endtask

  task automatic testLatency();
    runTrap(1'b0, 2, 2'd0, '0, '0, 32'h0000_00AA, 32'h1000, 32'h2000,
            32'hDEAD_0000, 32'h0000_4000, "latency");
    @(negedge clk);
    check("R2", "commitValid drops", XLEN'(commitValid), '0);
    check("R2", "epcOut held", epcOut, 32'h0000_4000);
  endtask

  task automatic testEcall();
    // Only the renamed supervisor-call bit is delegated
    runTrap(1'b0, 8, 2'd0, 32'h0000_0200, '0, '0, 32'h100, 32'h200, 32'h55, 32'h40, "ecall-U R10");
    runTrap(1'b0, 8, 2'd1, 32'h0000_0200, '0, '0, 32'h100, 32'h200, 32'h55, 32'h44, "ecall-S R10");
    runTrap(1'b0, 8, 2'd3, 32'hFFFF_FFFF, '0, '0, 32'h100, 32'h200, 32'h55, 32'h48, "ecall-M R10");
    runTrap(1'b0, 8, 2'd0, 32'h0000_0100, '0, '0, 32'h100, 32'h200, 32'h55, 32'h4C, "ecall-Ubit R10");
  endtask

  task automatic testWideCause();
    for (int c = XLEN; c < (1 << CAUSE_W); c++) begin
      runTrap(c[0], c, 2'd0, '1, '1, 32'h0000_0022, 32'h0000_3001,
              32'h0000_5001, 32'h1234_5678, 32'h0000_0800, "wide R4");
    end
  endtask

  task automatic testVectorSelect();
    runTrap(1'b1, 5, 2'd1, '0, 32'h20, 32'h0, 32'hAAAA_0001, 32'hBBBB_0000,
            '0, 32'h10, "svec R13");
    runTrap(1'b1, 5, 2'd1, '0, 32'h00, 32'h0, 32'hAAAA_0001, 32'hBBBB_0001,
            '0, 32'h14, "mvec R13");
    runTrap(1'b0, 5, 2'd1, 32'h20, '0, 32'h0, 32'hAAAA_0001, 32'hBBBB_0001,
            32'h77, 32'h18, "syncvec R11");
  endtask

  task automatic testTval();
    for (int c = 0; c < 16; c++) begin
      runTrap(1'b0, c, 2'd3, '0, '0, 32'h0, 32'h0, 32'h0000_0100,
              32'hCAFE_0000 + c, 32'h20, "tval R9");
    end
  endtask

  task automatic testSweep();
    logic [XLEN-1:0] dPat [3];
    logic [1:0] privs [3];
    dPat[0] = '0; dPat[1] = '1; dPat[2] = 32'hA5A5_5A5A;
    privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
    for (int c = 0; c < (1 << CAUSE_W); c++)
      for (int a = 0; a < 2; a++)
        for (int pi = 0; pi < 3; pi++)
          for (int di = 0; di < 3; di++)
            for (int vm = 0; vm < 4; vm++) begin
              runTrap(a[0], c, privs[pi], dPat[di], ~dPat[di],
                      32'h0000_0F0F ^ XLEN'(c * 37 + vm), 32'h8000_0100 | XLEN'(vm),
                      32'h9000_0200 | XLEN'(3 - vm), XLEN'(c) << 8 | 32'h1,
                      32'h0040_0000 + XLEN'(c * 4), "sweep");
            end
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testLatency();
    testEcall();
    testWideCause();
    testVectorSelect();
    testTval();
    testSweep();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule